// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter

This block serializes frames for a bit-synchronous HDLC-style line. It runs on the transmit clock and sends one line bit per clock. It takes 16-bit words from a show-ahead FIFO. Each word carries an end-of-frame mark and an odd mark, and the odd mark means that only the low byte of that final word belongs to the frame. The block wraps each frame in flag octets, inserts transparency zeros, and appends a frame check sequence (FCS). The FCS is 16 or 32 bits and is sent inverted, high-order bit first.

Sending is gated by a request/clear handshake. The request output rises while the FIFO holds data. A frame begins only at a flag boundary where the clear input is high, and the flag just sent acts as the opening flag. Between frames the line carries back-to-back flags.

If the FIFO runs dry before the end-of-frame word has been sent, the block aborts the frame with a run of ones. It then returns to flags and pulses an underrun output for one cycle.

Top module: `hdlc_tx`

## Requirements
- R1: Reset conditions and idle line.
  - While rst_ni is low: txd_o=1, rts_o=0, fifo_pop_o=0 and underrun_o=0.
  - After reset, with nothing to send, txd_o repeats the flag octet 01111110 and carries no frame.
- R2: Request and clear handshake.
  - rts_o goes high while the FIFO is non-empty.
  - No word is popped, and no frame starts, while cts_i is low.
  - A frame's first data bit follows a complete flag, and the pop that starts the frame happens only with rts_o and cts_i both high.
- R3: Data order on the line.
  - Each FIFO word is sent low byte first.
  - Within a byte, bit 0 goes first.
  - Consecutive words of a frame follow each other with no gap.
- R4: Zero insertion.
  - After five consecutive 1s in the data or FCS bits, a 0 is inserted. This includes the case where the five 1s end the FCS.
  - No 0 is inserted inside flags or aborts.
- R5: FCS generation.
  - fcs32_i=1 selects the 32-bit FCS, polynomial 0x04C11DB7. fcs32_i=0 selects the 16-bit FCS, polynomial 0x1021.
  - The register is preset to all ones and updated with each data bit d, in line order, before zero insertion: fb = msb ^ d, reg = (reg << 1) ^ (fb ? poly : 0).
  - Straight after the last data bit, the register is sent complemented, msb first, and is followed by a flag.
- R6: Odd-byte frames.
  - A word marked both end-of-frame (bit 16) and odd (bit 17) contributes only its low byte, so the frame holds an odd number of bytes.
  - The high byte of that word is ignored.
- R7: Underrun.
  - When a word that is not end-of-frame finishes and the FIFO is empty, the frame is aborted with eight 1s and flags follow.
  - underrun_o is high for exactly one cycle, on the cycle that shows the last abort bit.
  - No frame is delivered for the aborted data.
- R8: rts_o is low on the cycle after any cycle in which the block is sending flags and the FIFO is empty.
- R9: fifo_pop_o is asserted only when fifo_empty_i is low, and exactly one pop occurs per word sent or aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fcs32_i | input | 1 | 1 selects the 32-bit FCS, 0 selects the 16-bit FCS |
| cts_i | input | 1 | Clear to send |
| fifo_data_i | input | 16 | Head FIFO word, low byte sent first |
| fifo_eof_i | input | 1 | Head word is the last word of its frame |
| fifo_odd_i | input | 1 | Last word carries only its low byte |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_pop_o | output | 1 | Consume the head word at this clock edge |
| rts_o | output | 1 | Request to send |
| txd_o | output | 1 | Serial line output |
| underrun_o | output | 1 | One-cycle pulse at the end of an underrun abort |

## Verification
The assertions assume a show-ahead FIFO. Its head word and flags must change only at an edge where fifo_pop_o is high or a word is written, and fifo_empty_i must truthfully report the stored count. They also assume that fcs32_i holds steady for the length of a frame.

The bench models the FIFO as an array. Its read pointer moves only on a sampled pop, and words are written in whole frames at falling edges. fcs32_i is changed only when the line is idle and the FIFO is empty. cts_i may change at any time, because the block samples it only at flag boundaries.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [1:0] {
    ST_FLAG  = 2'd0,
    ST_DATA  = 2'd1,
    ST_FCS   = 2'd2,
    ST_ABORT = 2'd3
  } tx_state_e;
endpackage

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
  parameter int unsigned          W          = 32,
  parameter logic [W-1:0]         POLY_LONG  = 32'h04C1_1DB7,
  parameter logic [W/2-1:0]       POLY_SHORT = 16'h1021
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_i,
  input  logic init_i,
  input  logic upd_i,
  input  logic bit_i,
  input  logic shift_i,
  output logic tx_bit_o
);
  logic [W-1:0] r_q;
  logic         msb;
  logic [W-1:0] poly;

  assign msb      = long_i ? r_q[W-1] : r_q[W/2-1];
  assign poly     = long_i ? POLY_LONG : W'(POLY_SHORT);
  assign tx_bit_o = ~msb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      r_q <= '1;
    else if (init_i)  r_q <= '1;
    else if (upd_i)   r_q <= {r_q[W-2:0], 1'b0} ^ ((msb ^ bit_i) ? poly : '0);
    else if (shift_i) r_q <= {r_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/hdlc_tx_stuff.sv
module hdlc_tx_stuff #(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic src_bit_i,
  output logic stall_o,
  output logic bit_o
);
  localparam int OW = $clog2(RUN_LEN + 1);
  logic [OW-1:0] ones_q;

  // a pending run is closed even when the stuffed region has just ended
  assign stall_o = (ones_q == OW'(RUN_LEN));
  assign bit_o   = stall_o ? 1'b0 : src_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ones_q <= '0;
    else if (!bit_o || !en_i) ones_q <= '0;
    else                      ones_q <= ones_q + OW'(1);
  end
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned FCS_W     = 32,
  parameter int unsigned RUN_LEN   = 5,
  parameter int unsigned FLAG_LEN  = 8,
  parameter int unsigned ABORT_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fcs32_i,
  input  logic              cts_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  input  logic              fifo_eof_i,
  input  logic              fifo_odd_i,
  input  logic              fifo_empty_i,
  output logic              fifo_pop_o,
  output logic              rts_o,
  output logic              txd_o,
  output logic              underrun_o
);
  localparam int CNT_W = $clog2(FCS_W + 1);
  localparam logic [CNT_W-1:0] FLAG_LAST  = CNT_W'(FLAG_LEN - 1);
  localparam logic [CNT_W-1:0] ABORT_LAST = CNT_W'(ABORT_LEN - 1);
  localparam logic [CNT_W-1:0] WORD_LAST  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALF_LAST  = CNT_W'(WORD_W / 2 - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(FCS_W - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(FCS_W / 2 - 1);

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic              eof_q, odd_q;
  logic              txd_q, rts_q, und_q;

  logic              src_bit, line_bit, stall, adv, fcs_bit;
  logic              stuff_en, in_flag;
  logic              flag_end, word_end, fcs_end, abort_end;
  logic              start, more;
  logic [CNT_W-1:0]  word_last, fcs_last;

  assign in_flag   = (state_q == ST_FLAG);
  assign stuff_en  = (state_q == ST_DATA) || (state_q == ST_FCS);
  assign adv       = !stall;
  assign word_last = (eof_q && odd_q) ? HALF_LAST : WORD_LAST;
  assign fcs_last  = fcs32_i ? LONG_LAST : SHORT_LAST;

  always_comb begin
    unique case (state_q)
      ST_FLAG:  src_bit = (cnt_q != '0) && (cnt_q != FLAG_LAST);
      ST_DATA:  src_bit = sh_q[0];
      ST_FCS:   src_bit = fcs_bit;
      default:  src_bit = 1'b1;
    endcase
  end

  assign flag_end  = adv && in_flag && (cnt_q == FLAG_LAST);
  assign word_end  = adv && (state_q == ST_DATA) && (cnt_q == word_last);
  assign fcs_end   = adv && (state_q == ST_FCS) && (cnt_q == fcs_last);
  assign abort_end = adv && (state_q == ST_ABORT) && (cnt_q == ABORT_LAST);
  assign start     = flag_end && rts_q && cts_i && !fifo_empty_i;
  assign more      = word_end && !eof_q && !fifo_empty_i;
  assign fifo_pop_o = start || more;

  hdlc_tx_stuff #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (stuff_en),
    .src_bit_i (src_bit),
    .stall_o   (stall),
    .bit_o     (line_bit)
  );

  hdlc_tx_fcs #(.W(FCS_W)) u_fcs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .long_i   (fcs32_i),
    .init_i   (in_flag),
    .upd_i    (adv && (state_q == ST_DATA)),
    .bit_i    (sh_q[0]),
    .shift_i  (adv && (state_q == ST_FCS)),
    .tx_bit_o (fcs_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FLAG;
      cnt_q   <= '0;
      sh_q    <= '0;
      eof_q   <= 1'b0;
      odd_q   <= 1'b0;
      txd_q   <= 1'b1;
      rts_q   <= 1'b0;
      und_q   <= 1'b0;
    end else begin
      txd_q <= line_bit;
      rts_q <= !in_flag || !fifo_empty_i;
      und_q <= abort_end;
      if (fifo_pop_o) begin
        sh_q  <= fifo_data_i;
        eof_q <= fifo_eof_i;
        odd_q <= fifo_odd_i;
      end else if (adv && state_q == ST_DATA) begin
        sh_q <= sh_q >> 1;
      end
      if (adv) begin
        unique case (state_q)
          ST_FLAG: begin
            cnt_q <= flag_end ? '0 : cnt_q + CNT_W'(1);
            if (start) state_q <= ST_DATA;
          end
          ST_DATA: begin
            cnt_q <= word_end ? '0 : cnt_q + CNT_W'(1);
            if (word_end) begin
              if (eof_q)                 state_q <= ST_FCS;
              else if (fifo_empty_i)     state_q <= ST_ABORT;
            end
          end
          ST_FCS: begin
            cnt_q <= fcs_end ? '0 : cnt_q + CNT_W'(1);
            if (fcs_end) state_q <= ST_FLAG;
          end
          default: begin
            cnt_q <= abort_end ? '0 : cnt_q + CNT_W'(1);
            if (abort_end) state_q <= ST_FLAG;
          end
        endcase
      end
    end
  end

  assign txd_o      = txd_q;
  assign rts_o      = rts_q;
  assign underrun_o = und_q;
endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk #(
  parameter int unsigned RUN_LEN = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic fifo_pop_o,
  input logic fifo_empty_i,
  input logic rts_o,
  input logic cts_i,
  input logic in_flag,
  input logic stuff_en,
  input logic txd_o,
  input logic underrun_o
);
  logic       en_q;
  logic [3:0] run_q;

  // run of line ones that came from the stuffed region
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      run_q <= '0;
    end else begin
      en_q <= stuff_en;
      if (!txd_o || !en_q) run_q <= '0;
      else if (run_q != 4'hF) run_q <= run_q + 4'd1;
    end
  end

  a_r9_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !fifo_empty_i);
  a_r2_pop_needs_rts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> rts_o);
  a_r2_start_needs_cts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_pop_o && in_flag) |-> cts_i);
  a_r4_run_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 4'(RUN_LEN));
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o);
  a_r7_pulse_on_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> txd_o);
  a_r8_rts_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_flag && fifo_empty_i) |=> !rts_o);
endmodule

bind hdlc_tx hdlc_tx_chk #(.RUN_LEN(RUN_LEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_pop_o   (fifo_pop_o),
  .fifo_empty_i (fifo_empty_i),
  .rts_o        (rts_o),
  .cts_i        (cts_i),
  .in_flag      (in_flag),
  .stuff_en     (stuff_en),
  .txd_o        (txd_o),
  .underrun_o   (underrun_o)
);

// File: tb/hdlc_tx_tb.sv
module hdlc_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // [15:8] byte count, [7:4] pattern kind, [0] 32-bit FCS
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0100, 16'h0201, 16'h0510, 16'h0611,
    16'h0320, 16'h0931, 16'h0430, 16'h0C00
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fcs32_i = 1'b0;
  logic        cts_i = 1'b0;
  logic [15:0] fifo_data_i;
  logic        fifo_eof_i, fifo_odd_i, fifo_empty_i;
  logic        fifo_pop_o, rts_o, txd_o, underrun_o;

  logic [17:0] fmem [64];
  int head = 0, tail = 0, pops = 0, bad_pops = 0, pushes = 0;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // line decoder state
  int   ones = 0, nb = 0, stuffs = 0, frames = 0, aborts = 0, flags = 0;
  int   last_len = 0, last_stuff = 0, und_pulses = 0, und_cycles = 0;
  logic in_frame = 1'b0, und_prev = 1'b0;
  logic rx [512];
  logic last_bits [512];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign fifo_data_i  = fmem[head[5:0]][15:0];
  assign fifo_eof_i   = fmem[head[5:0]][16];
  assign fifo_odd_i   = fmem[head[5:0]][17];
  assign fifo_empty_i = (head == tail);

  hdlc_tx u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fcs32_i(fcs32_i), .cts_i(cts_i),
    .fifo_data_i(fifo_data_i), .fifo_eof_i(fifo_eof_i), .fifo_odd_i(fifo_odd_i),
    .fifo_empty_i(fifo_empty_i), .fifo_pop_o(fifo_pop_o), .rts_o(rts_o),
    .txd_o(txd_o), .underrun_o(underrun_o)
  );

  always @(posedge clk_i) begin
    if (rst_ni && fifo_pop_o) begin
      pops <= pops + 1;
      if (head == tail) bad_pops <= bad_pops + 1;
      else head <= head + 1;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (underrun_o) und_cycles++;
      if (underrun_o && !und_prev) und_pulses++;
      und_prev = underrun_o;
      if (txd_o) begin
        ones++;
        if (ones == 7) begin
          aborts++; in_frame = 1'b0; nb = 0;
        end else if (ones < 7 && nb < 512) begin
          rx[nb] = 1'b1; nb++;
        end
      end else begin
        if (ones == 6) begin
          flags++;
          nb = (nb >= 7) ? nb - 7 : 0;
          if (in_frame && nb > 0) begin
            for (int i = 0; i < 512; i++) last_bits[i] = rx[i];
            last_len = nb; last_stuff = stuffs; frames++;
          end
          in_frame = 1'b1; nb = 0; stuffs = 0;
        end else if (ones == 5) begin
          stuffs++;
        end else if (ones < 5 && nb < 512) begin
          rx[nb] = 1'b0; nb++;
        end
        ones = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  function automatic logic [7:0] gen_byte(input int kind, input int i);
    case (kind)
      0:       return 8'(i * 37 + 5);
      1:       return 8'hFF;
      2:       return 8'h7E;
      default: return 8'hF8 ^ 8'(i * 29);
    endcase
  endfunction

  task automatic push_frame(input int n, input int kind);
    int nw;
    logic [7:0] lo, hi;
    logic last;
    nw = (n + 1) / 2;
    for (int w = 0; w < nw; w++) begin
      lo = gen_byte(kind, 2*w);
      hi = (2*w + 1 < n) ? gen_byte(kind, 2*w + 1) : 8'hA5;
      last = (w == nw - 1);
      fmem[tail[5:0]] = {last && (n % 2 == 1), last, hi, lo};
      tail++; pushes++;
    end
  endtask

  task automatic wait_frame(input int f0);
    for (int c = 0; c < 3000 && frames == f0; c++) @(negedge clk_i);
  endtask

  task automatic verify_frame(input int n, input int kind, input bit f32, input int f0);
    logic [31:0] crc, poly;
    logic d, fb;
    int w, dbits, bad_d, bad_f, exp_st, run;
    logic eb [512];
    check(frames == f0 + 1, "R3 frame delivered", frames - f0, 1);
    w = f32 ? 32 : 16;
    poly = f32 ? 32'h04C11DB7 : 32'h0000_1021;
    dbits = n * 8;
    crc = '1;
    for (int i = 0; i < dbits; i++) begin
      d = gen_byte(kind, i / 8)[i % 8];
      eb[i] = d;
      fb = crc[w-1] ^ d;
      crc = {crc[30:0], 1'b0} ^ (fb ? poly : 32'h0);
    end
    for (int j = 0; j < w; j++) eb[dbits + j] = ~crc[w-1-j];
    check(last_len == dbits + w, (n % 2 == 1) ? "R6 odd length" : "R5 length", last_len, dbits + w);
    bad_d = 0; bad_f = 0;
    for (int i = 0; i < dbits + w && i < 512; i++) begin
      if (last_bits[i] !== eb[i]) begin
        if (i < dbits) bad_d++; else bad_f++;
      end
    end
    check(bad_d == 0, "R3 data bits", bad_d, 0);
    check(bad_f == 0, "R5 fcs bits", bad_f, 0);
    exp_st = 0; run = 0;
    for (int i = 0; i < dbits + w; i++) begin
      if (eb[i]) begin
        run++;
        if (run == 5) begin exp_st++; run = 0; end
      end else run = 0;
    end
    check(last_stuff == exp_st, "R4 inserted zeros", last_stuff, exp_st);
    repeat (20) @(negedge clk_i);
    check(rts_o == 1'b0, "R8 rts dropped", int'(rts_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int f0, a0, u0, c0, fl0, n, kind;
    bit f32;
    for (int i = 0; i < 64; i++) fmem[i] = '0;
    repeat (3) @(negedge clk_i);
    check(txd_o == 1'b1, "R1 reset txd", int'(txd_o), 1);
    check(rts_o == 1'b0, "R1 reset rts", int'(rts_o), 0);
    check(fifo_pop_o == 1'b0, "R1 reset pop", int'(fifo_pop_o), 0);
    check(underrun_o == 1'b0, "R1 reset underrun", int'(underrun_o), 0);
    rst_ni = 1'b1;
    repeat (60) @(negedge clk_i);
    check(flags >= 5, "R1 idle flags", flags, 5);
    check(frames == 0, "R1 no idle frame", frames, 0);
    check(rts_o == 1'b0, "R8 idle rts low", int'(rts_o), 0);

    // clear held low: request rises, nothing moves
    f0 = frames;
    fcs32_i = VEC[0][0];
    push_frame(int'(VEC[0][15:8]), int'(VEC[0][7:4]));
    repeat (100) @(negedge clk_i);
    check(rts_o == 1'b1, "R2 rts with data", int'(rts_o), 1);
    check(pops == 0, "R2 no pop without cts", pops, 0);
    check(frames == f0, "R2 no frame without cts", frames, f0);
    cts_i = 1'b1;
    wait_frame(f0);
    verify_frame(int'(VEC[0][15:8]), int'(VEC[0][7:4]), VEC[0][0], f0);

    for (int v = 1; v < NVEC; v++) begin
      n = int'(VEC[v][15:8]); kind = int'(VEC[v][7:4]); f32 = VEC[v][0];
      fcs32_i = f32;
      f0 = frames;
      push_frame(n, kind);
      wait_frame(f0);
      verify_frame(n, kind, f32, f0);
    end

    // underrun: a single word with no end mark
    f0 = frames; a0 = aborts; u0 = und_pulses; c0 = und_cycles;
    fmem[tail[5:0]] = {1'b0, 1'b0, 16'h3412};
    tail++; pushes++;
    for (int c = 0; c < 500 && und_pulses == u0; c++) @(negedge clk_i);
    fl0 = flags;
    check(und_pulses == u0 + 1, "R7 underrun pulse", und_pulses - u0, 1);
    repeat (40) @(negedge clk_i);
    check(und_cycles == c0 + 1, "R7 pulse width", und_cycles - c0, 1);
    check(aborts == a0 + 1, "R7 abort on line", aborts - a0, 1);
    check(frames == f0, "R7 no frame delivered", frames - f0, 0);
    check(flags >= fl0 + 3, "R7 flags resume", flags - fl0, 3);
    check(rts_o == 1'b0, "R8 rts after abort", int'(rts_o), 0);

    check(bad_pops == 0, "R9 pop on empty", bad_pops, 0);
    check(pops == pushes, "R9 pop count", pops, pushes);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule